// File: doc/BRIEF.md
# Missing-Pulse Presence Watchdog

This block checks that one monitored clock is still alive. It runs entirely in a free-running reference clock domain. The monitored clock passes through a two-stage synchronizer and then a glitch filter. A level change counts only after it has held for a programmed number of reference cycles. Each qualified rising edge restarts a timeout counter. If no qualified rising edge arrives before the counter reaches the programmed limit, the block raises a missing-pulse fault with a timeout cause code. The limit is the longest allowed period times the tolerated missed-edge count, plus an allowance. The fault stays latched until firmware clears it, and firmware can clear it only after the clock has been seen again.

The block is meant to run alongside a frequency-window checker. The checker handles drift. The watchdog catches short dropouts that a gated count would average away. After a clock switch or a reset elsewhere, a one-cycle hold-off request masks presence detection for a programmed number of cycles. Evaluation then restarts from zero. The configuration inputs are static: the block copies them only while it is disabled. A saturating counter reports how many reference cycles the fault lasted before the clock came back.

The state machine has four states. IDLE is disabled. ARMED is watching. HOLD is the masked hold-off window. FAULT is latched. The transitions are start (IDLE to ARMED on enable), holdoff request (ARMED to HOLD), holdoff expiry (HOLD to ARMED), timeout (ARMED to FAULT), accepted clear (FAULT to ARMED, or to IDLE when disabled) and disable (ARMED or HOLD to IDLE).

Top module: `presence_watchdog`

## Requirements
- R1: After reset, `fault` is 0, `fault_cause` is 2'b00, `fault_dur` is 0 and `holdoff_act` is 0.
- R2: While enabled, monitored high and low phases of at least the glitch minimum, with rising edges spaced closer than limit = `cfg_period_max` × `cfg_miss_cnt` + `cfg_allowance` reference cycles, never raise a fault.
- R3: When the monitored clock stops after a qualified rising edge, `fault` rises no earlier than limit cycles and no later than limit + glitch minimum + 4 cycles after that rising level was applied.
- R4: `fault_cause` reads 2'b01 (timeout) whenever `fault` is 1 and 2'b00 whenever `fault` is 0.
- R5: A monitored high or low phase shorter than `cfg_glitch_min` reference cycles is not an edge. It neither restarts the timeout nor permits a clear. A glitch minimum of 0 acts as 1.
- R6: A raised fault stays set until an accepted clear. A hold-off request and a low `enable` leave it set.
- R7: A `fault_clear` pulse is accepted only if a qualified rising edge arrived during the fault, or arrives in the same cycle. Acceptance drops `fault`, sets the cause to 2'b00 and returns to ARMED, or to IDLE when `enable` is low.
- R8: `fault_dur` is 0 in the cycle the fault rises. It then grows by one each cycle until the first qualified rising edge, after which it holds. It saturates at all ones.
- R9: `holdoff_start` in ARMED holds `holdoff_act` high for exactly `cfg_holdoff_len` cycles (0 acts as 1). No fault is raised in that window, and the timeout restarts from zero afterwards. The request wins over a timeout expiring in the same cycle, and it is ignored in IDLE and FAULT.
- R10: Configuration inputs are taken only while `enable` is low. Changes made while enabled have no effect on the limit in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run monitoring; configuration is copied while low |
| mon_clk | input | 1 | Monitored clock, asynchronous to clk_ref |
| cfg_period_max | input | CNT_W | Longest allowed monitored period, reference cycles |
| cfg_miss_cnt | input | MISS_W | Tolerated missed-edge count |
| cfg_allowance | input | CNT_W | Extra cycles added to the timeout limit |
| cfg_glitch_min | input | GLT_W | Minimum phase width, reference cycles, for a qualified level |
| cfg_holdoff_len | input | CNT_W | Hold-off window length, reference cycles |
| holdoff_start | input | 1 | One-cycle request to open a hold-off window |
| fault_clear | input | 1 | Request to clear the latched fault |
| fault | output | 1 | Latched missing-pulse fault |
| fault_cause | output | 2 | 2'b00 none, 2'b01 timeout |
| fault_dur | output | DUR_W | Cycles the fault persisted before the clock returned |
| holdoff_act | output | 1 | Hold-off window open |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a timeout expiry and a hold-off request. The bench sweeps the request across every cycle around the expected expiry point. It then judges that exactly one of `holdoff_act` and `fault` is high in the next cycle, and that a granted hold-off never ends in a fault. The second pair is a clear request and a qualified edge. A second sweep moves `fault_clear` across the cycles in which a returning edge is recognized. It checks that clears well before recognition are refused and clears well after it are accepted. Whatever the outcome at the boundary offset, a later clear must always succeed.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FAULT = 2'd3
    } pw_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_TIMEOUT = 2'b01
    } pw_cause_t;

endpackage

// File: rtl/pw_edge_qual.sv
module pw_edge_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int GLT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_in,
    input  logic [GLT_W-1:0] min_width,
    output logic             rise_pulse
);

    localparam int RUN_W = GLT_W + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    logic                   level_q;
    logic [GLT_W-1:0]       run_cnt;
    logic [RUN_W-1:0]       run_next;

    generate
        if (SYNC_STAGES < 2) begin : g_bad_depth
            initial $error("pw_edge_qual needs at least two synchronizer stages");
        end
    endgenerate

    // synchronizer chain into the reference domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], mon_in};
        end
    end

    assign smp      = sync_q[SYNC_STAGES-1];
    assign run_next = {1'b0, run_cnt} + RUN_W'(1);

    // a level is accepted once it has differed from the held level for min_width cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q    <= 1'b0;
            run_cnt    <= '0;
            rise_pulse <= 1'b0;
        end else begin
            rise_pulse <= 1'b0;
            if (smp != level_q) begin
                if (run_next >= {1'b0, min_width}) begin
                    level_q    <= smp;
                    run_cnt    <= '0;
                    rise_pulse <= smp;
                end else begin
                    run_cnt <= run_next[GLT_W-1:0];
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/pw_cfg_hold.sv
module pw_cfg_hold #(
    parameter int CNT_W  = 16,
    parameter int MISS_W = 4,
    parameter int GLT_W  = 4,
    parameter int LIM_W  = CNT_W + MISS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  period_max,
    input  logic [MISS_W-1:0] miss_cnt,
    input  logic [CNT_W-1:0]  allowance,
    input  logic [GLT_W-1:0]  glitch_min,
    input  logic [CNT_W-1:0]  holdoff_len,
    output logic [LIM_W-1:0]  lim,
    output logic [GLT_W-1:0]  thr,
    output logic [CNT_W-1:0]  hold
);

    logic [LIM_W-1:0] prod;

    assign prod = LIM_W'(period_max) * LIM_W'(miss_cnt) + LIM_W'(allowance);

    // configuration is only copied while monitoring is disabled; zeros act as one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim  <= LIM_W'(1);
            thr  <= GLT_W'(1);
            hold <= CNT_W'(1);
        end else if (!enable) begin
            lim  <= (prod == '0) ? LIM_W'(1) : prod;
            thr  <= (glitch_min == '0) ? GLT_W'(1) : glitch_min;
            hold <= (holdoff_len == '0) ? CNT_W'(1) : holdoff_len;
        end
    end

endmodule

// File: rtl/pw_dur_count.sv
module pw_dur_count #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [DUR_W-1:0] dur
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dur <= '0;
        end else if (start) begin
            dur <= '0;
        end else if (run && (dur != '1)) begin
            dur <= dur + DUR_W'(1);
        end
    end

endmodule

// File: rtl/presence_watchdog.sv
module presence_watchdog
    import pw_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MISS_W      = 4,
    parameter int GLT_W       = 4,
    parameter int DUR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mon_clk,
    input  logic [CNT_W-1:0]  cfg_period_max,
    input  logic [MISS_W-1:0] cfg_miss_cnt,
    input  logic [CNT_W-1:0]  cfg_allowance,
    input  logic [GLT_W-1:0]  cfg_glitch_min,
    input  logic [CNT_W-1:0]  cfg_holdoff_len,
    input  logic              holdoff_start,
    input  logic              fault_clear,
    output logic              fault,
    output logic [1:0]        fault_cause,
    output logic [DUR_W-1:0]  fault_dur,
    output logic              holdoff_act
);

    localparam int LIM_W = CNT_W + MISS_W + 1;

    pw_state_t        state_q, state_d;
    pw_cause_t        cause_q;
    logic [LIM_W-1:0] lim;
    logic [GLT_W-1:0] thr;
    logic [CNT_W-1:0] hold_len;
    logic [LIM_W-1:0] wd_cnt;
    logic [CNT_W-1:0] hold_cnt;
    logic             q_edge;
    logic             edge_seen;
    logic             expire;
    logic             hold_done;
    logic             clear_ok;

    pw_edge_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .GLT_W       (GLT_W)
    ) u_qual (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .mon_in     (mon_clk),
        .min_width  (thr),
        .rise_pulse (q_edge)
    );

    pw_cfg_hold #(
        .CNT_W  (CNT_W),
        .MISS_W (MISS_W),
        .GLT_W  (GLT_W),
        .LIM_W  (LIM_W)
    ) u_cfg (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .enable      (enable),
        .period_max  (cfg_period_max),
        .miss_cnt    (cfg_miss_cnt),
        .allowance   (cfg_allowance),
        .glitch_min  (cfg_glitch_min),
        .holdoff_len (cfg_holdoff_len),
        .lim         (lim),
        .thr         (thr),
        .hold        (hold_len)
    );

    assign expire    = !q_edge && ((wd_cnt + LIM_W'(1)) >= lim);
    assign hold_done = (hold_cnt + CNT_W'(1)) >= hold_len;
    assign clear_ok  = fault_clear && (edge_seen || q_edge);

    // next-state decisions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_ARMED;                 // start
            end
            ST_ARMED: begin
                if (!enable)            state_d = ST_IDLE;      // disable
                else if (holdoff_start) state_d = ST_HOLD;      // holdoff request wins
                else if (expire)        state_d = ST_FAULT;     // timeout
            end
            ST_HOLD: begin
                if (!enable)        state_d = ST_IDLE;          // disable
                else if (hold_done) state_d = ST_ARMED;         // holdoff expiry
            end
            ST_FAULT: begin
                if (clear_ok) state_d = enable ? ST_ARMED : ST_IDLE; // accepted clear
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wd_cnt    <= '0;
            hold_cnt  <= '0;
            edge_seen <= 1'b0;
            cause_q   <= CAUSE_NONE;
        end else begin
            state_q <= state_d;

            if ((state_q == ST_ARMED) && (state_d == ST_ARMED) && !q_edge) begin
                wd_cnt <= wd_cnt + LIM_W'(1);
            end else begin
                wd_cnt <= '0;
            end

            if ((state_q == ST_HOLD) && (state_d == ST_HOLD)) begin
                hold_cnt <= hold_cnt + CNT_W'(1);
            end else begin
                hold_cnt <= '0;
            end

            if (state_q != ST_FAULT) begin
                edge_seen <= 1'b0;
            end else if (q_edge) begin
                edge_seen <= 1'b1;
            end

            if ((state_q == ST_ARMED) && (state_d == ST_FAULT)) begin
                cause_q <= CAUSE_TIMEOUT;
            end else if ((state_q == ST_FAULT) && (state_d != ST_FAULT)) begin
                cause_q <= CAUSE_NONE;
            end
        end
    end

    pw_dur_count #(
        .DUR_W (DUR_W)
    ) u_dur (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .start ((state_q == ST_ARMED) && (state_d == ST_FAULT)),
        .run   ((state_q == ST_FAULT) && !edge_seen && !q_edge),
        .dur   (fault_dur)
    );

    // outputs
    always_comb begin
        fault       = (state_q == ST_FAULT);
        holdoff_act = (state_q == ST_HOLD);
        fault_cause = cause_q;
    end

endmodule

// File: rtl/presence_watchdog_chk.sv
module presence_watchdog_chk #(
    parameter int DUR_W = 16
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic             fault,
    input logic [1:0]       fault_cause,
    input logic [DUR_W-1:0] fault_dur,
    input logic             holdoff_act,
    input logic             fault_clear
);

    AST_CAUSE_ON_FAULT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fault |-> (fault_cause == 2'b01)); // R4

    AST_CAUSE_IDLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !fault |-> (fault_cause == 2'b00)); // R4

    AST_FAULT_LATCHED: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (fault && !fault_clear) |=> fault); // R6

    AST_HOLDOFF_NO_FAULT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        holdoff_act |-> !fault); // R9

    AST_HOLDOFF_EXIT_CLEAN: assert property (@(posedge clk_ref) disable iff (!rst_n)
        holdoff_act |=> !fault); // R9

    AST_DUR_ZERO_ON_ENTRY: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(fault) |-> (fault_dur == '0)); // R8

    AST_DUR_NO_DECREASE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (fault && $past(fault)) |-> (fault_dur >= $past(fault_dur))); // R8

endmodule

bind presence_watchdog presence_watchdog_chk #(
    .DUR_W (DUR_W)
) u_chk (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .fault       (fault),
    .fault_cause (fault_cause),
    .fault_dur   (fault_dur),
    .holdoff_act (holdoff_act),
    .fault_clear (fault_clear)
);

// File: tb/presence_watchdog_tb.sv
module presence_watchdog_tb;

    localparam int CNT_W  = 16;
    localparam int MISS_W = 4;
    localparam int GLT_W  = 4;
    localparam int DUR_W  = 16;

    localparam int P_MAX = 20;
    localparam int N_MIS = 3;
    localparam int ALLOW = 10;
    localparam int T     = 3;
    localparam int H     = 100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              mon = 1'b0;
    logic [CNT_W-1:0]  cfg_period;
    logic [MISS_W-1:0] cfg_miss;
    logic [CNT_W-1:0]  cfg_allow;
    logic [GLT_W-1:0]  cfg_glitch;
    logic [CNT_W-1:0]  cfg_hold;
    logic              holdoff_start = 1'b0;
    logic              fault_clear = 1'b0;
    logic              fault;
    logic [1:0]        fault_cause;
    logic [DUR_W-1:0]  fault_dur;
    logic              holdoff_act;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int L;

    always #4 clk = ~clk;

    presence_watchdog #(
        .CNT_W  (CNT_W),
        .MISS_W (MISS_W),
        .GLT_W  (GLT_W),
        .DUR_W  (DUR_W)
    ) u_dut (
        .clk_ref         (clk),
        .rst_n           (rst_n),
        .enable          (enable),
        .mon_clk         (mon),
        .cfg_period_max  (cfg_period),
        .cfg_miss_cnt    (cfg_miss),
        .cfg_allowance   (cfg_allow),
        .cfg_glitch_min  (cfg_glitch),
        .cfg_holdoff_len (cfg_hold),
        .holdoff_start   (holdoff_start),
        .fault_clear     (fault_clear),
        .fault           (fault),
        .fault_cause     (fault_cause),
        .fault_dur       (fault_dur),
        .holdoff_act     (holdoff_act)
    );

    function automatic int limit_of(input int p, input int m, input int a);
        return p * m + a;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic qpulse(input int hi);
        mon = 1'b1;
        cyc(hi);
        mon = 1'b0;
    endtask

    task automatic recover();
        qpulse(T + 1);
        cyc(T + 4);
        fault_clear = 1'b1;
        cyc(1);
        fault_clear = 1'b0;
        cyc(1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int d1;
        int d2;
        int el;
        void'($urandom(32'h5EED_C10C));
        cfg_period = CNT_W'(P_MAX);
        cfg_miss   = MISS_W'(N_MIS);
        cfg_allow  = CNT_W'(ALLOW);
        cfg_glitch = GLT_W'(T);
        cfg_hold   = CNT_W'(H);
        L = limit_of(P_MAX, N_MIS, ALLOW);

        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        chk(fault == 1'b0, "R1 fault after reset", fault, 0);
        chk(fault_cause == 2'b00, "R1 cause after reset", fault_cause, 0);
        chk(fault_dur == '0, "R1 duration after reset", fault_dur, 0);
        chk(holdoff_act == 1'b0, "R1 holdoff after reset", holdoff_act, 0);
        cyc(3);
        enable = 1'b1;
        cyc(2);

        // R2 directed: steady clock well inside the limit
        for (int i = 0; i < 20; i++) begin
            qpulse(8);
            cyc(8);
        end
        chk(fault == 1'b0, "R2 steady clock", fault, 0);

        // R2 random: phases between glitch minimum and 12 cycles
        for (int i = 0; i < 40; i++) begin
            qpulse(T + int'($urandom_range(9)));
            cyc(T + int'($urandom_range(9)));
            chk(fault == 1'b0, "R2 random clock", fault, 0);
        end

        // R3 / R4: clock stops
        qpulse(4);
        cyc(L - 4);
        chk(fault == 1'b0, "R3 no early fault", fault, 0);
        cyc(T + 4);
        chk(fault == 1'b1, "R3 fault after limit", fault, 1);
        chk(fault_cause == 2'b01, "R4 timeout cause", fault_cause, 1);

        // R8: duration grows while clock absent
        d1 = int'(fault_dur);
        cyc(10);
        chk(int'(fault_dur) == d1 + 10, "R8 duration counting", fault_dur, d1 + 10);

        // R5 / R7: glitches are no edge, clear refused
        for (int i = 0; i < 3; i++) begin
            qpulse(T - 1);
            cyc(T + 1);
        end
        fault_clear = 1'b1;
        cyc(1);
        fault_clear = 1'b0;
        cyc(2);
        chk(fault == 1'b1, "R7 clear refused without edge", fault, 1);
        chk(int'(fault_dur) > d1 + 10, "R5 glitches do not stop duration", fault_dur, d1 + 11);

        // R6 / R9: hold-off and disable leave latched fault
        holdoff_start = 1'b1;
        cyc(1);
        holdoff_start = 1'b0;
        cyc(1);
        chk(fault == 1'b1, "R6 fault kept over holdoff", fault, 1);
        chk(holdoff_act == 1'b0, "R9 holdoff ignored in fault", holdoff_act, 0);
        enable = 1'b0;
        cyc(3);
        chk(fault == 1'b1, "R6 fault kept over disable", fault, 1);
        enable = 1'b1;
        cyc(1);

        // R8: duration freezes after a qualified edge
        qpulse(T + 1);
        cyc(T + 4);
        d2 = int'(fault_dur);
        cyc(10);
        chk(int'(fault_dur) == d2, "R8 duration frozen", fault_dur, d2);

        // R7: accepted clear
        fault_clear = 1'b1;
        cyc(1);
        fault_clear = 1'b0;
        chk(fault == 1'b0, "R7 clear accepted", fault, 0);
        chk(fault_cause == 2'b00, "R7 cause cleared", fault_cause, 0);

        // R5: glitch-only stimulus does not keep the watchdog alive
        qpulse(4);
        el = 4;
        while (el < L + T + 4) begin
            int g;
            int q;
            g = 1 + int'($urandom_range(T - 2));
            q = T + int'($urandom_range(2));
            cyc(1);
            mon = 1'b1;
            cyc(g);
            mon = 1'b0;
            cyc(q);
            el += 1 + g + q;
        end
        chk(fault == 1'b1, "R5 glitches ignored", fault, 1);
        recover();

        // R9: hold-off window
        qpulse(4);
        cyc(2);
        holdoff_start = 1'b1;
        cyc(1);
        holdoff_start = 1'b0;
        chk(holdoff_act == 1'b1, "R9 holdoff opens", holdoff_act, 1);
        cyc(H - 1);
        chk(holdoff_act == 1'b1, "R9 holdoff length", holdoff_act, 1);
        chk(fault == 1'b0, "R9 no fault in holdoff", fault, 0);
        cyc(1);
        chk(holdoff_act == 1'b0, "R9 holdoff ends", holdoff_act, 0);
        cyc(L - 2);
        chk(fault == 1'b0, "R9 timeout restarted", fault, 0);
        cyc(3);
        chk(fault == 1'b1, "R9 fault after restart", fault, 1);
        recover();

        // R10: config changes while enabled ignored
        cfg_period = CNT_W'(2);
        cfg_allow  = CNT_W'(0);
        qpulse(4);
        cyc(L - 4);
        chk(fault == 1'b0, "R10 old limit in use", fault, 0);
        cyc(T + 4);
        chk(fault == 1'b1, "R10 fault at old limit", fault, 1);
        recover();
        enable = 1'b0;
        cfg_period = CNT_W'(P_MAX);
        cfg_allow  = CNT_W'(ALLOW);
        cyc(2);
        enable = 1'b1;
        cyc(2);

        // R9 same cycle: hold-off request swept around timeout expiry
        for (int k = L - 2; k <= L + T + 5; k++) begin
            qpulse(4);
            cyc(k - 4);
            holdoff_start = 1'b1;
            cyc(1);
            holdoff_start = 1'b0;
            chk((holdoff_act ^ fault) == 1'b1, "R9 holdoff versus expiry", {holdoff_act, fault}, 1);
            if (holdoff_act) begin
                cyc(H - 2);
                chk(fault == 1'b0, "R9 granted holdoff stays clean", fault, 0);
            end
            recover();
            enable = 1'b0;
            cyc(2);
            enable = 1'b1;
            cyc(2);
        end

        // R7 same cycle: clear swept across edge recognition
        for (int k = 0; k <= T + 5; k++) begin
            cyc(L + T + 6);
            for (int i = 0; i < T + 8; i++) begin
                mon = (i < T + 2);
                fault_clear = (i == k);
                cyc(1);
            end
            fault_clear = 1'b0;
            cyc(1);
            if (k <= T - 1) chk(fault == 1'b1, "R7 early clear refused", fault, 1);
            if (k >= T + 3) chk(fault == 1'b0, "R7 late clear accepted", fault, 0);
            if (fault) begin
                fault_clear = 1'b1;
                cyc(1);
                fault_clear = 1'b0;
            end
            chk(fault == 1'b0, "R7 clear after edge", fault, 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule